// File: doc/BRIEF.md
# Sampled-Edge Frequency Detector and Loop Controller

This block steers a digital frequency-locked loop so that the divided oscillator clock settles at exactly twice the reference frequency. It runs on the divided clock and samples the reference on both edges of that clock. Each pair of divided-clock periods yields one 4-sample word, and at the target frequency that word covers exactly one reference period.

The block compares each new word with the word before it. A one-place rotation of the word shows which way the reference edge is drifting. The block latches that direction as a mode and steps a binary oscillator control code one place for every word that is not a steady lock word. Because the mode holds until an opposite drift is seen, the code moves monotonically toward the target.

A run of identical lock words fills a 12-bit confirmation counter. When that counter reaches its maximum, the block raises a lock flag and freezes the loop. The oscillator, divider and DAC sit outside the block.

Top module: `sedfd_loop`

## Requirements
- R1: While `rst_n` is low and immediately after reset, `code_o` is mid-scale (128 at the default width), `mode_o` is HOLD (2'b00), `freq_lock_o` is 0, and the confirmation counter is zero.
- R2: `ref_in` is sampled on the rising and the falling edge of `clk`, and each sample passes through two flops clocked on that same edge. Four consecutive samples (rise, fall, rise, fall over two periods) form `samp_o`, with the oldest sample in bit 3. A reference with a period of two `clk` periods and a 50% duty cycle therefore gives one of 0011, 0110, 1100 or 1001.
- R3: A word that is one of the lock patterns 0011, 0110, 1100 or 1001 and equals the previous word is a stable word. It leaves `code_o` unchanged and increments the confirmation counter.
- R4: A word equal to the previous word rotated left by one place ({prev[2:0],prev[3]}, reference faster than half the divided clock) sets `mode_o` to UP (2'b01). A word equal to the previous word rotated right by one place sets DOWN (2'b10). Any other word leaves the mode unchanged, and the mode never returns to HOLD before reset.
- R5: Every word that is not stable moves `code_o` by exactly one step in the direction of the mode, using the mode just decided. In HOLD the code does not move.
- R6: `code_o` saturates at 0 and at 255 and never wraps.
- R7: Any word that is not stable clears the confirmation counter. `freq_lock_o` rises when the counter reaches 4095, that is, after 4095 consecutive stable words.
- R8: Once `freq_lock_o` is high, it stays high until reset, and `code_o` and `mode_o` no longer change whatever the reference does.
- R9: While the mode stays fixed, `code_o` moves in one direction only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock; both edges sample the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, treated as asynchronous data |
| mode_o | output | 2 | Latched direction: 00 HOLD, 01 UP, 10 DOWN |
| code_o | output | CODE_W (8) | Binary oscillator control code |
| freq_lock_o | output | 1 | Frequency lock flag |
| samp_o | output | 4 | Current sample word, oldest sample in bit 3 |

## Verification
A reference sample reaches `samp_o` two `clk` cycles after it is taken by its synchronizer, plus up to two further cycles while the word is assembled. Mode, code and counter update on the cycle after a word is complete, so any result lags its stimulus by up to five cycles. The bench therefore appends four stable words after each stimulus phase before it reads the outputs half a cycle away from the clock edge. It checks only quantities that do not depend on where the word boundaries fall: saturated code values, latched mode, counter windows with hundreds of words of margin, and a cycle-by-cycle monotonic monitor.

// File: rtl/sedfd_loop.sv
module sedfd_loop #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  output logic [1:0]        mode_o,
  output logic [CODE_W-1:0] code_o,
  output logic              freq_lock_o,
  output logic [3:0]        samp_o
);

  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DN   = 2'b10;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic r_s1, r_s2, f_s1, f_s2;
  logic half, have_word, prev_ok, vld;
  logic [1:0] first_pair;
  logic [3:0] s_cur, s_prev;
  logic [1:0] mode, mode_n;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_s1 <= 1'b0;
      r_s2 <= 1'b0;
    end else begin
      r_s1 <= ref_in;
      r_s2 <= r_s1;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      f_s1 <= 1'b0;
      f_s2 <= 1'b0;
    end else begin
      f_s1 <= ref_in;
      f_s2 <= f_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      half       <= 1'b0;
      first_pair <= 2'b00;
      s_cur      <= 4'b0000;
      s_prev     <= 4'b0000;
      have_word  <= 1'b0;
      prev_ok    <= 1'b0;
      vld        <= 1'b0;
    end else begin
      half <= ~half;
      vld  <= half;
      if (!half) first_pair <= {r_s2, f_s2};
      else begin
        s_cur     <= {first_pair, r_s2, f_s2};
        s_prev    <= s_cur;
        have_word <= 1'b1;
        prev_ok   <= have_word;
      end
    end

  wire [3:0] rot_l  = {s_prev[2:0], s_prev[3]};
  wire [3:0] rot_r  = {s_prev[0], s_prev[3:1]};
  wire lock_pat     = (s_cur == 4'b0011) || (s_cur == 4'b0110) ||
                      (s_cur == 4'b1100) || (s_cur == 4'b1001);
  wire same         = (s_cur == s_prev);
  wire go_up        = prev_ok && !same && (s_cur == rot_l) && (rot_l != rot_r);
  wire go_dn        = prev_ok && !same && (s_cur == rot_r) && (rot_l != rot_r);
  wire stable       = prev_ok && same && lock_pat;
  wire locked       = (cnt == CNT_MAX);

  assign mode_n = go_up ? M_UP : (go_dn ? M_DN : mode);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_HOLD;
      code <= CODE_MID;
      cnt  <= '0;
    end else if (vld && !locked) begin
      mode <= mode_n;
      if (stable) cnt <= cnt + 1'b1;
      else begin
        cnt <= '0;
        if (mode_n == M_UP && code != CODE_MAX) code <= code + 1'b1;
        else if (mode_n == M_DN && code != '0) code <= code - 1'b1;
      end
    end

  assign mode_o      = mode;
  assign code_o      = code;
  assign freq_lock_o = locked;
  assign samp_o      = s_cur;

endmodule

// File: rtl/sedfd_loop_chk.sv
module sedfd_loop_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [CODE_W-1:0] code,
  input logic              lock
);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(code));

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mode));

  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1));

  a_r9_up_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (code > $past(code)) |-> (mode == 2'b01));

  a_r9_dn_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (code < $past(code)) |-> (mode == 2'b10));

  a_r4_no_hold_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> (mode != 2'b00));

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

bind sedfd_loop sedfd_loop_chk #(.CODE_W(CODE_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .mode (mode_o),
  .code (code_o),
  .lock (freq_lock_o)
);

// File: tb/sedfd_loop_bench.sv
module sedfd_loop_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [1:0] mode_o;
  logic [7:0] code_o;
  logic freq_lock_o;
  logic [3:0] samp_o;

  int checks = 0;
  int errors = 0;
  int mono_dir = 0;
  int mono_bad = 0;
  logic [7:0] last_code = 8'd128;
  logic pend = 1'b0;
  bit have_pend = 1'b0;

  localparam int NT = 5;
  localparam int T_KIND [NT] = '{0, 1, 0, 2, 0};
  localparam int T_LEN  [NT] = '{100, 600, 200, 800, 1000};
  localparam int T_MODE [NT] = '{0, 1, 1, 2, 2};
  localparam int T_CODE [NT] = '{128, 255, 255, 0, 0};

  always #4 clk = ~clk;

  sedfd_loop u_sedfd_loop (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode_o(mode_o),
    .code_o(code_o), .freq_lock_o(freq_lock_o), .samp_o(samp_o)
  );

  always @(negedge clk) begin
    if (mono_dir > 0 && code_o < last_code) mono_bad++;
    if (mono_dir < 0 && code_o > last_code) mono_bad++;
    last_code = code_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pair(input logic r, input logic f);
    ref_in = r;
    @(posedge clk);
    #2 ref_in = f;
    @(negedge clk);
    #2;
  endtask

  task automatic put(input logic b);
    if (!have_pend) begin
      pend = b;
      have_pend = 1'b1;
    end else begin
      have_pend = 1'b0;
      pair(pend, b);
    end
  endtask

  task automatic period4();
    put(1'b0); put(1'b0); put(1'b1); put(1'b1);
  endtask

  task automatic steady(input int n);
    for (int i = 0; i < n; i++) period4();
  endtask

  task automatic drift(input bit faster, input int n);
    for (int i = 0; i < n; i++) begin
      period4(); period4(); period4();
      if (faster) begin
        put(1'b0); put(1'b1); put(1'b1);
      end else begin
        put(1'b0); put(1'b0); put(1'b0); put(1'b1); put(1'b1);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [7:0] held_code;
    logic [1:0] held_mode;
    repeat (3) @(posedge clk);
    #2 chk("R1 code in reset", code_o, 128);
    @(negedge clk);
    #2 rst_n = 1'b1;
    chk("R1 mode after reset", mode_o, 0);
    chk("R1 lock after reset", freq_lock_o, 0);
    chk("R1 code after reset", code_o, 128);

    for (int t = 0; t < NT; t++) begin
      mono_bad = 0;
      mono_dir = (T_KIND[t] == 1) ? 1 : (T_KIND[t] == 2) ? -1 : 0;
      if (T_KIND[t] == 0) steady(T_LEN[t]);
      else drift(T_KIND[t] == 1, T_LEN[t]);
      steady(4);
      mono_dir = 0;
      chk($sformatf("R4 mode entry %0d", t), mode_o, T_MODE[t]);
      chk($sformatf("R6 R5 code entry %0d", t), code_o, T_CODE[t]);
      chk($sformatf("R7 lock entry %0d", t), freq_lock_o, 0);
      if (T_KIND[t] != 0) chk($sformatf("R9 monotonic entry %0d", t), mono_bad, 0);
      else chk($sformatf("R2 lock word entry %0d", t),
               int'(samp_o == 4'b0011 || samp_o == 4'b0110 ||
                    samp_o == 4'b1100 || samp_o == 4'b1001), 1);
    end

    held_code = code_o;
    steady(20);
    chk("R3 code holds on stable words", code_o, held_code);

    steady(2000);
    put(1'b0); put(1'b0); put(1'b0); put(1'b0);
    steady(3000);
    chk("R7 counter cleared by break", freq_lock_o, 0);
    steady(1200);
    chk("R7 lock after full count", freq_lock_o, 1);

    held_code = code_o;
    held_mode = mode_o;
    drift(1'b1, 50);
    drift(1'b0, 50);
    steady(4);
    chk("R8 lock sticky", freq_lock_o, 1);
    chk("R8 code frozen", code_o, held_code);
    chk("R8 mode frozen", mode_o, held_mode);

    rst_n = 1'b0;
    #10;
    chk("R1 mid-run reset code", code_o, 128);
    chk("R1 mid-run reset mode", mode_o, 0);
    chk("R1 mid-run reset lock", freq_lock_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule